// File: doc/BRIEF.md
# Bus-Snooping Cartridge Read Responder

This block sits on the cartridge side of an 8-bit microprocessor bus and services a fixed handshake routine run by the CPU. It does not decode read addresses. It watches the bus one cycle at a time: address, data in and the read/write strobe. It recognises the start of the routine from a write to a select address. It then drives three result nibbles onto the data bus at the cycles where the CPU's three absolute loads are predicted to sample them. The routine has five steps in order: the select write, an indexed-indirect store (6 cycles, writing in its last cycle), a zero-page store (3 cycles, writing in its last), then three 4-cycle absolute loads from a port address with opcodes 0xAE, 0xAC and 0xAD.

A DMA engine elsewhere on the bus can steal cycles and stall the CPU for 3 or 4 cycles. The block checks for the expected bus pattern at a series of checkpoints. When a checkpoint misses, it pushes its schedule back by the gap that matches that stall signature and checks again. If the pattern still does not appear, the stall cannot be explained. The block then abandons the sequence, leaves the bus undriven and sets a sticky fault flag. The port address must be chosen so that its low nibble differs from bits 11:8 and is not 0xE, 0xC or 0xD; 0x5A05 is the default. This keeps the operand bytes distinguishable from the load opcodes.

Top module: `cart_snoop_responder`

## Requirements
- R1: After reset, `bus_oe` and `fault` are 0 and stay 0 until a routine is seen.
- R2: A write to `SEL_ADDR` is cycle 0 and starts a sequence. With no stall, the zero-page store writes in cycle 9, and the block drives in cycles 13, 17 and 21. These are 4, 8 and 12 cycles after that write, and each drive lasts exactly one cycle.
- R3: The three drives carry `res_lo`, then `res_hi`, then `res_chk` in `bus_dout[3:0]`, with `bus_dout[7:4]` = 0.
- R4: If R/W is not low in cycle 6, the block waits 4 more cycles and expects the store write there. A match there moves every later event 4 cycles later.
- R5: If the zero-page store write is missing, the block re-checks 3 cycles later and then 1 cycle after that. The first match shifts the rest of the schedule by 3 or 4 cycles.
- R6: If the first load's opcode 0xAE is missing in its opcode cycle, the block re-checks 3 cycles later. It does not drive in the cycle that was originally scheduled.
- R7: If the port low byte (0x05) is missing from the data bus in the operand cycle after a load opcode, the block re-checks 4 cycles later before it drives.
- R8: If the port high byte (0x5A) is missing in the cycle after the low byte, the block re-checks 4 cycles later before it drives.
- R9: `bus_oe` is high only while R/W is high, never in two consecutive cycles, and at most three times per sequence.
- R10: A checkpoint that still misses after its allowed re-checks aborts the sequence, releases the bus and sets `fault`. A missing opcode for the second or third load (0xAC, 0xAD) aborts at once.
- R11: `fault` stays set until the next write to `SEL_ADDR`, which clears it and starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one rising edge per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Address bus for the current cycle |
| bus_din | input | 8 | Data bus as seen in the current cycle |
| bus_rw | input | 1 | 1 = CPU read cycle, 0 = CPU write cycle |
| res_lo | input | 4 | Result nibble returned by the first load |
| res_hi | input | 4 | Result nibble returned by the second load |
| res_chk | input | 4 | Verification nibble returned by the third load |
| bus_dout | output | 8 | Value driven on the data bus |
| bus_oe | output | 1 | Data bus drive enable |
| fault | output | 1 | Sticky flag for an abandoned sequence |

## Verification
The bench inserts a stall window at each checkpoint in turn: inside the indirect store's reads, on that store's write, inside and on the zero-page store, on a load's operand fetches, and on a load's read cycle. For each case it predicts the exact drive cycles. A design with a wrong retry gap would drive into a stolen cycle or miss the CPU's read. A design that lacked the single 1-cycle extension after the 3-cycle retry would fault on a 4-cycle stall during the zero-page store. Unexplainable stalls check that the bus is released and `fault` is raised rather than data being driven blindly. A clean run afterwards confirms that the select write clears the flag.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STA,
        PH_STX,
        PH_OP,
        PH_LO,
        PH_HI,
        PH_DRV
    } phase_t;

    localparam int WAIT_W   = 3;
    localparam int LD_W     = 2;
    localparam int NUM_LDS  = 3;
    localparam int TRY_W    = 2;

    // cycles skipped before the first checkpoint of each store
    localparam logic [WAIT_W-1:0] STA_SKIP = WAIT_W'(5);
    localparam logic [WAIT_W-1:0] STX_SKIP = WAIT_W'(2);

    typedef struct packed {
        phase_t             ph;
        logic [WAIT_W-1:0]  wt;
        logic [TRY_W-1:0]   tries;
        logic [LD_W-1:0]    ld;
        logic               fault;
    } seq_t;

    function automatic logic [7:0] load_opcode(input logic [LD_W-1:0] idx);
        case (idx)
            2'd0:    return 8'hAE;
            2'd1:    return 8'hAC;
            default: return 8'hAD;
        endcase
    endfunction

    // may this checkpoint be retried once more?
    function automatic logic retry_allowed(input phase_t ph,
                                           input logic [TRY_W-1:0] tries,
                                           input logic [LD_W-1:0] ld);
        case (ph)
            PH_STA:  return tries == '0;
            PH_STX:  return tries < TRY_W'(2);
            PH_OP:   return (ld == '0) && (tries == '0);
            PH_LO:   return tries == '0;
            PH_HI:   return tries == '0;
            default: return 1'b0;
        endcase
    endfunction

    // cycles to skip before the re-check (stall length minus one)
    function automatic logic [WAIT_W-1:0] retry_skip(input phase_t ph,
                                                     input logic [TRY_W-1:0] tries);
        case (ph)
            PH_STX:  return (tries == '0) ? WAIT_W'(2) : WAIT_W'(0);
            PH_OP:   return WAIT_W'(2);
            default: return WAIT_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/snoop_match.sv
module snoop_match
    import snoop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 16'h5A10,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h5A05
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rw,
    input  logic [LD_W-1:0]   ld,
    output logic              sel_hit,
    output logic              wr_hit,
    output logic              op_hit,
    output logic              lo_hit,
    output logic              hi_hit
);
    localparam logic [DATA_W-1:0] PORT_LO = PORT_ADDR[DATA_W-1:0];
    localparam logic [DATA_W-1:0] PORT_HI = PORT_ADDR[ADDR_W-1:DATA_W];

    always_comb begin
        wr_hit  = !bus_rw;
        sel_hit = !bus_rw && (bus_addr == SEL_ADDR);
        op_hit  = bus_rw && (bus_din == DATA_W'(load_opcode(ld)));
        lo_hit  = bus_rw && (bus_din == PORT_LO);
        hi_hit  = bus_rw && (bus_din == PORT_HI);
    end
endmodule

// File: rtl/snoop_seq.sv
module snoop_seq
    import snoop_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_hit,
    input  logic            wr_hit,
    input  logic            op_hit,
    input  logic            lo_hit,
    input  logic            hi_hit,
    output phase_t          ph,
    output logic [LD_W-1:0] ld,
    output logic            fault
);
    localparam logic [LD_W-1:0] LAST_LD = LD_W'(NUM_LDS - 1);

    seq_t seq_d, seq_q;
    logic pass;

    always_comb begin
        case (seq_q.ph)
            PH_STA, PH_STX: pass = wr_hit;
            PH_OP:          pass = op_hit;
            PH_LO:          pass = lo_hit;
            PH_HI:          pass = hi_hit;
            default:        pass = 1'b0;
        endcase
    end

    always_comb begin
        seq_d = seq_q;
        if (sel_hit) begin
            seq_d.ph    = PH_STA;
            seq_d.wt    = STA_SKIP;
            seq_d.tries = '0;
            seq_d.ld    = '0;
            seq_d.fault = 1'b0;
        end else begin
            case (seq_q.ph)
                PH_IDLE: ;
                PH_DRV: begin
                    seq_d.tries = '0;
                    if (seq_q.ld == LAST_LD) begin
                        seq_d.ph = PH_IDLE;
                    end else begin
                        seq_d.ld = seq_q.ld + LD_W'(1);
                        seq_d.ph = PH_OP;
                    end
                end
                default: begin
                    if (seq_q.wt != '0) begin
                        seq_d.wt = seq_q.wt - WAIT_W'(1);
                    end else if (pass) begin
                        seq_d.tries = '0;
                        seq_d.wt    = '0;
                        case (seq_q.ph)
                            PH_STA: begin
                                seq_d.ph = PH_STX;
                                seq_d.wt = STX_SKIP;
                            end
                            PH_STX:  seq_d.ph = PH_OP;
                            PH_OP:   seq_d.ph = PH_LO;
                            PH_LO:   seq_d.ph = PH_HI;
                            default: seq_d.ph = PH_DRV;
                        endcase
                    end else if (retry_allowed(seq_q.ph, seq_q.tries, seq_q.ld)) begin
                        seq_d.tries = seq_q.tries + TRY_W'(1);
                        seq_d.wt    = retry_skip(seq_q.ph, seq_q.tries);
                    end else begin
                        seq_d.ph    = PH_IDLE;
                        seq_d.fault = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, wt: '0, tries: '0, ld: '0, fault: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ph    = seq_q.ph;
    assign ld    = seq_q.ld;
    assign fault = seq_q.fault;
endmodule

// File: rtl/snoop_drive.sv
module snoop_drive
    import snoop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  phase_t            ph,
    input  logic [LD_W-1:0]   ld,
    input  logic              bus_rw,
    input  logic [NIB_W-1:0]  res_lo,
    input  logic [NIB_W-1:0]  res_hi,
    input  logic [NIB_W-1:0]  res_chk,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe
);
    localparam int PAD_W = DATA_W - NIB_W;

    logic [NIB_W-1:0] nib;

    always_comb begin
        case (ld)
            2'd0:    nib = res_lo;
            2'd1:    nib = res_hi;
            default: nib = res_chk;
        endcase
    end

    assign bus_dout = {{PAD_W{1'b0}}, nib};
    assign bus_oe   = (ph == PH_DRV) && bus_rw;
endmodule

// File: rtl/cart_snoop_responder.sv
module cart_snoop_responder
    import snoop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    localparam int ADDR_W = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 16'h5A10,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h5A05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rw,
    input  logic [NIB_W-1:0]  res_lo,
    input  logic [NIB_W-1:0]  res_hi,
    input  logic [NIB_W-1:0]  res_chk,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              fault
);
    logic            sel_hit, wr_hit, op_hit, lo_hit, hi_hit;
    phase_t          ph;
    logic [LD_W-1:0] ld;

    snoop_match #(
        .DATA_W    (DATA_W),
        .SEL_ADDR  (SEL_ADDR),
        .PORT_ADDR (PORT_ADDR)
    ) u_match (
        .bus_addr (bus_addr),
        .bus_din  (bus_din),
        .bus_rw   (bus_rw),
        .ld       (ld),
        .sel_hit  (sel_hit),
        .wr_hit   (wr_hit),
        .op_hit   (op_hit),
        .lo_hit   (lo_hit),
        .hi_hit   (hi_hit)
    );

    snoop_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_hit (sel_hit),
        .wr_hit  (wr_hit),
        .op_hit  (op_hit),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .ph      (ph),
        .ld      (ld),
        .fault   (fault)
    );

    snoop_drive #(
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) u_drive (
        .ph       (ph),
        .ld       (ld),
        .bus_rw   (bus_rw),
        .res_lo   (res_lo),
        .res_hi   (res_hi),
        .res_chk  (res_chk),
        .bus_dout (bus_dout),
        .bus_oe   (bus_oe)
    );
endmodule

// File: rtl/snoop_chk.sv
module snoop_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 16'h5A10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rw,
    input logic              bus_oe,
    input logic              fault
);
    logic       sel_wr;
    logic [7:0] since_q;
    logic       armed_q;
    logic [1:0] ndrv_q;

    assign sel_wr = !bus_rw && (bus_addr == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
            ndrv_q  <= '0;
        end else if (sel_wr) begin
            since_q <= '0;
            armed_q <= 1'b1;
            ndrv_q  <= '0;
        end else begin
            if (since_q != 8'hFF) since_q <= since_q + 8'd1;
            if (bus_oe && ndrv_q != 2'd3) ndrv_q <= ndrv_q + 2'd1;
        end
    end

    // R9
    oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |=> !bus_oe);

    // R9
    oe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (ndrv_q < 2'd3));

    // R2
    oe_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (armed_q && since_q >= 8'd12));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !bus_oe);

    // R11
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> !fault);
endmodule

bind cart_snoop_responder snoop_chk #(
    .ADDR_W   (16),
    .SEL_ADDR (SEL_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rw   (bus_rw),
    .bus_oe   (bus_oe),
    .fault    (fault)
);

// File: tb/sim_cart_snoop_responder.sv
module sim_cart_snoop_responder;
    localparam logic [15:0] SEL  = 16'h5A10;
    localparam logic [15:0] PORT = 16'h5A05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'hFFFF;
    logic [7:0]  bus_din = 8'hEA;
    logic        bus_rw = 1'b1;
    logic [3:0]  res_lo = '0, res_hi = '0, res_chk = '0;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic        fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int         at;
        logic [7:0] val;
        string      req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    cart_snoop_responder #(.SEL_ADDR(SEL), .PORT_ADDR(PORT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_rw(bus_rw), .res_lo(res_lo), .res_hi(res_hi), .res_chk(res_chk),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .fault(fault)
    );

    // monitor: every drive must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_oe) begin
            checks++;
            if (!bus_rw) begin
                errors++;
                $display("FAIL R9 drive during write cycle %0d: rw=%0b expected 1", cyc, bus_rw);
            end
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected drive at cycle %0d: value %02h expected none", cyc, bus_dout);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.at != cyc || it.val != bus_dout) begin
                    errors++;
                    $display("FAIL %s drive: cycle %0d value %02h expected cycle %0d value %02h",
                             it.req, cyc, bus_dout, it.at, it.val);
                end
            end
        end
    end

    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw);
        @(posedge clk);
        #1;
        bus_addr = a;
        bus_din  = d;
        bus_rw   = rw;
        cyc++;
    endtask

    task automatic nominal(input int i, output logic [15:0] a, output logic [7:0] d, output logic rw);
        rw = 1'b1;
        a  = 16'hC000 + 16'(i);
        d  = 8'h30 + 8'(i);
        if (i == 0) begin
            a = SEL; d = 8'h00; rw = 1'b0;
        end else if (i == 6) begin
            a = 16'h0300; d = 8'h42; rw = 1'b0;
        end else if (i == 7) begin
            d = 8'h86;
        end else if (i == 8) begin
            d = 8'h20;
        end else if (i == 9) begin
            a = 16'h0020; d = 8'h03; rw = 1'b0;
        end else if (i >= 10) begin
            case ((i - 10) % 4)
                0: d = ((i - 10) / 4 == 0) ? 8'hAE : (((i - 10) / 4 == 1) ? 8'hAC : 8'hAD);
                1: d = PORT[7:0];
                2: d = PORT[15:8];
                default: begin a = PORT; d = 8'hFF; end
            endcase
        end
    endtask

    // run the routine with a stall of len cycles inserted before nominal cycle ins
    task automatic run_case(input string req, input int ins, input int len,
                            input logic [2:0] mask, input logic exp_fault,
                            input logic [3:0] lo, input logic [3:0] hi, input logic [3:0] ck);
        logic [15:0] a;
        logic [7:0]  d;
        logic        rw;
        int          base;
        res_lo = lo; res_hi = hi; res_chk = ck;
        base = 0;
        for (int i = 0; i < 22; i++) begin
            if (i == ins) begin
                for (int s = 0; s < len; s++) bus(16'hC7F0, 8'h55, 1'b1);
            end
            nominal(i, a, d, rw);
            bus(a, d, rw);
            if (i == 0) begin
                base = cyc;
                for (int k = 0; k < 3; k++) begin
                    if (mask[k]) begin
                        item_t it;
                        int rd;
                        rd = 13 + 4 * k;
                        it.at  = base + rd + ((ins >= 0 && ins < rd) ? len : 0);
                        it.val = {4'h0, (k == 0) ? lo : ((k == 1) ? hi : ck)};
                        it.req = req;
                        sb.push_back(it);
                    end
                end
            end
        end
        for (int j = 0; j < 6; j++) bus(16'hFFFF, 8'hEA, 1'b1);
        @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s missing drives: %0d pending expected 0", req, sb.size());
            sb.delete();
        end
        checks++;
        if (fault !== exp_fault) begin
            errors++;
            $display("FAIL %s fault flag: %0b expected %0b", req, fault, exp_fault);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: run not finished expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) bus(16'hFFFF, 8'hEA, 1'b1);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (bus_oe !== 1'b0 || fault !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: oe=%0b fault=%0b expected 0 0", bus_oe, fault);
        end
        // R2 R3 clean routine
        run_case("R2", -1, 0, 3'b111, 1'b0, 4'h3, 4'hC, 4'h9);
        run_case("R3", -1, 0, 3'b111, 1'b0, 4'hF, 4'h0, 4'h6);
        // R4 stall inside indirect store reads
        run_case("R4", 3, 4, 3'b111, 1'b0, 4'h1, 4'h2, 4'h4);
        // R5 stall starting on indirect store write (3) and inside zero-page reads (4)
        run_case("R5", 7, 3, 3'b111, 1'b0, 4'h5, 4'hA, 4'h7);
        run_case("R5", 8, 4, 3'b111, 1'b0, 4'hB, 4'h8, 4'hE);
        // R6 stall starting on the zero-page store write
        run_case("R6", 10, 3, 3'b111, 1'b0, 4'hD, 4'h3, 4'h1);
        // R7 missing low operand on second load
        run_case("R7", 15, 4, 3'b111, 1'b0, 4'h2, 4'h9, 4'hC);
        // R8 missing high operand on third load
        run_case("R8", 20, 4, 3'b111, 1'b0, 4'h6, 4'h4, 4'hB);
        // R10 unexplained 3-cycle stall in the indirect store
        run_case("R10", 3, 3, 3'b000, 1'b1, 4'h7, 4'h7, 4'h7);
        // R11 clean routine clears the flag
        run_case("R11", -1, 0, 3'b111, 1'b0, 4'h8, 4'h1, 4'hA);
        // R10 stall on first load read: blind drive, then second opcode missing
        run_case("R10", 13, 4, 3'b001, 1'b1, 4'hE, 4'h5, 4'h2);
        // R11 idle cycles do not clear the flag
        repeat (10) bus(16'hFFFF, 8'hEA, 1'b1);
        @(negedge clk);
        checks++;
        if (fault !== 1'b1) begin
            errors++;
            $display("FAIL R11 sticky fault: %0b expected 1", fault);
        end
        run_case("R11", -1, 0, 3'b111, 1'b0, 4'h4, 4'hF, 4'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule